// File: doc/BRIEF.md
# Always-On Wake-Up Timer Core

This block is the always-powered half of a wake-up timer. It runs in a slow 32 kHz clock domain and keeps a 48-bit elapsed-time counter. The counter advances by one on each enable tick. Software sees the counter as three 16-bit words and can load each word on its own. The timer also holds a 48-bit alarm value. When the alarm is armed and the count equals the alarm value, the timer sets a sticky interrupt. That interrupt also drives a wake request toward the power controller. It stays set through a core power-down and remains set until software clears it.

Software reads a multi-word count coherently through a keyed gateway register. Writing the capture key copies all three count words into three hold registers in a single cycle. The hold registers keep that value until the next capture. A power-on reset clears every register and sets a failure flag. That flag tells software the counts must be reprogrammed. While the flag is set, alarms are suppressed. Register access is a single-cycle write port plus a combinational read port, both in the slow domain.

Top module: `wake_timer`

## Requirements
- R1: After reset the count, alarm and snapshot words read 0, the status word reads 0, `alarm_irq` and `wake_req` are low, and the control word reads 0x0002 (arm bit 0 clear, failure bit 1 set).
- R2: Each cycle with `tick` high and no count-word write, the 48-bit count rises by one. It wraps from all ones to zero and carries across word boundaries. Without `tick` it holds.
- R3: Writing address 4, 5 or 6 replaces the low, middle or high count word. In that cycle the count does not advance. Reads at the same addresses return the words.
- R4: The alarm words are at addresses 8, 9 and 10 (low, middle, high). When control bit 0 is set, the failure flag is clear and the count equals the alarm, `alarm_irq` is high from the next cycle. With bit 0 clear, a match raises nothing.
- R5: `alarm_irq` is sticky and is read as status bit 0 at address 1. Writing 1 to that bit clears it. If a match occurs in the same cycle, the clear has no effect.
- R6: `wake_req` equals `alarm_irq` in every cycle.
- R7: Writing 0x7627 to the gateway at address 2 copies the count as it stood in that cycle into the snapshot words at addresses 12, 13 and 14 (low, middle, high). The copy is readable the next cycle. The snapshot words hold until the next such write, even while the count moves.
- R8: Any other value written to the gateway leaves the snapshot words unchanged.
- R9: The failure flag is control bit 1. Writing the control word with bit 1 set clears it. Writing bit 1 as 0 leaves it unchanged. While the flag is set, a count/alarm match does not raise `alarm_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| alarm_irq | output | 1 | Sticky alarm interrupt |
| wake_req | output | 1 | Wake request to power controller |

## Verification
The two functions that can land in the same cycle are an alarm match and a software clear of the sticky interrupt. The bench provokes the collision by stopping the count on the alarm value, so the match stays true, and then writing the status clear. Because the match wins, the interrupt must still read high afterwards. A second clear, written once the count has moved past the alarm, must then drop both the interrupt and the wake request.

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [WORD-1:0] wr_data,
  input  logic [3:0]      rd_addr,
  output logic [WORD-1:0] rd_data,
  output logic            alarm_irq,
  output logic            wake_req
);
  localparam int W = 3 * WORD;
  localparam logic [3:0] A_CTL = 4'd0, A_STAT = 4'd1, A_GATE = 4'd2;
  localparam logic [3:0] A_CNT = 4'd4, A_ALM = 4'd8, A_SNAP = 4'd12;
  localparam logic [WORD-1:0] KEY_SNAP = WORD'(16'h7627);

  logic [W-1:0] cnt, cnt_nxt, alm, snap;
  logic         arm, fail;

  wire cnt_ld  = wr_en && wr_addr >= A_CNT && wr_addr < A_CNT + 4'd3;
  wire snap_go = wr_en && wr_addr == A_GATE && wr_data == KEY_SNAP;
  wire irq_clr = wr_en && wr_addr == A_STAT && wr_data[0];
  wire match   = arm && !fail && cnt == alm;

  always_comb begin
    cnt_nxt = cnt;
    if (cnt_ld) begin
      for (int i = 0; i < 3; i++)
        if (wr_addr == A_CNT + 4'(i)) cnt_nxt[i*WORD +: WORD] = wr_data;
    end else if (tick) begin
      cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      alm       <= '0;
      snap      <= '0;
      arm       <= 1'b0;
      fail      <= 1'b1;
      alarm_irq <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (snap_go) snap <= cnt;
      for (int i = 0; i < 3; i++)
        if (wr_en && wr_addr == A_ALM + 4'(i)) alm[i*WORD +: WORD] <= wr_data;
      if (wr_en && wr_addr == A_CTL) begin
        arm <= wr_data[0];
        if (wr_data[1]) fail <= 1'b0;
      end
      if (match) alarm_irq <= 1'b1;
      else if (irq_clr) alarm_irq <= 1'b0;
    end
  end

  assign wake_req = alarm_irq;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTL:           rd_data = WORD'({fail, arm});
      A_STAT:          rd_data = WORD'(alarm_irq);
      A_CNT:           rd_data = cnt[0 +: WORD];
      A_CNT + 4'd1:    rd_data = cnt[WORD +: WORD];
      A_CNT + 4'd2:    rd_data = cnt[2*WORD +: WORD];
      A_ALM:           rd_data = alm[0 +: WORD];
      A_ALM + 4'd1:    rd_data = alm[WORD +: WORD];
      A_ALM + 4'd2:    rd_data = alm[2*WORD +: WORD];
      A_SNAP:          rd_data = snap[0 +: WORD];
      A_SNAP + 4'd1:   rd_data = snap[WORD +: WORD];
      A_SNAP + 4'd2:   rd_data = snap[2*WORD +: WORD];
      default:         rd_data = '0;
    endcase
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_ld |=> cnt == $past(cnt) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(cnt));
  // R4
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> alarm_irq);
  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq && !irq_clr |=> alarm_irq);
  // R9
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_irq && (fail || !arm) |=> !alarm_irq);
  // R9
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !(wr_en && wr_addr == A_CTL && wr_data[1]) |=> fail);
  // R7
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_go |=> snap == $past(cnt));
  // R8
  snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_go |=> $stable(snap));
endmodule

// File: tb/test_wake_timer.sv
module test_wake_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [47:0] LOAD [NV] = '{48'h0000_0000_FFFF, 48'hFFFF_FFFF_FFFF,
                                        48'h1234_5678_9ABC, 48'h0000_FFFF_FFFE};
  localparam int          NTK  [NV] = '{1, 1, 3, 2};
  localparam logic [47:0] EXPC [NV] = '{48'h0000_0001_0000, 48'h0000_0000_0000,
                                        48'h1234_5678_9ABF, 48'h0001_0000_0000};

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic alarm_irq, wake_req;
  int total = 0, bad = 0;
  bit finished = 0;

  wake_timer i_wake_timer (.clk, .rst_n, .tick, .wr_en, .wr_addr, .wr_data,
                           .rd_addr, .rd_data, .alarm_irq, .wake_req);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr48(input logic [3:0] base, input logic [47:0] v);
    wr(base, v[15:0]); wr(base + 4'd1, v[31:16]); wr(base + 4'd2, v[47:32]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic rd48(input logic [3:0] base, output logic [47:0] v);
    rd_addr = base;        #1 v[15:0]  = rd_data;
    rd_addr = base + 4'd1; #1 v[31:16] = rd_data;
    rd_addr = base + 4'd2; #1 v[47:32] = rd_data;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    rd_addr = a; #1 v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] v;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd16(4'd0, w); chk("R1 ctl", 48'(w), 48'h2);
    rd16(4'd1, w); chk("R1 stat", 48'(w), 48'h0);
    rd48(4'd4, v); chk("R1 cnt", v, 48'h0);
    rd48(4'd8, v); chk("R1 alarm", v, 48'h0);
    rd48(4'd12, v); chk("R1 snap", v, 48'h0);
    chk("R1 irq/wake", {46'h0, alarm_irq, wake_req}, 48'h0);

    // R2 R3 R7 vector table
    for (int k = 0; k < NV; k++) begin
      wr48(4'd4, LOAD[k]);
      rd48(4'd4, v); chk("R3 load", v, LOAD[k]);
      ticks(NTK[k]);
      wr(4'd2, 16'h7627);
      rd48(4'd4, v); chk("R2 count", v, EXPC[k]);
      rd48(4'd12, v); chk("R7 snap", v, EXPC[k]);
    end

    // R7 hold while counting, R8 bad keys ignored
    wr48(4'd4, 48'h0000_0000_0042);
    ticks(5);
    wr(4'd2, 16'h7626);
    wr(4'd2, 16'h0000);
    rd48(4'd12, v); chk("R8 snap unchanged", v, 48'h0001_0000_0000);
    rd48(4'd4, v); chk("R2 count", v, 48'h47);

    // R9 failure flag blocks alarm
    wr48(4'd8, 48'h5);
    wr(4'd0, 16'h0001);
    rd16(4'd0, w); chk("R9 fail kept", 48'(w), 48'h3);
    wr48(4'd4, 48'h3);
    ticks(4);
    @(negedge clk);
    chk("R9 no irq while fail", 48'(alarm_irq), 48'h0);

    // R4 R6 match raises irq
    wr(4'd0, 16'h0003);
    rd16(4'd0, w); chk("R9 fail cleared", 48'(w), 48'h1);
    wr48(4'd4, 48'h3);
    ticks(2);
    @(negedge clk);
    chk("R4 irq", 48'(alarm_irq), 48'h1);
    chk("R6 wake", 48'(wake_req), 48'h1);
    rd16(4'd1, w); chk("R5 status", 48'(w), 48'h1);

    // R5 clear collides with live match
    wr(4'd1, 16'h0001);
    chk("R5 clear vs match", 48'(alarm_irq), 48'h1);
    ticks(1);
    wr(4'd1, 16'h0001);
    chk("R5 cleared", 48'(alarm_irq), 48'h0);
    chk("R6 wake low", 48'(wake_req), 48'h0);

    // R4 arm bit off
    wr(4'd0, 16'h0000);
    wr48(4'd4, 48'h4);
    ticks(1);
    @(negedge clk);
    chk("R4 disarmed", 48'(alarm_irq), 48'h0);

    // R5 sticky across later ticks, wide compare
    wr(4'd0, 16'h0001);
    wr48(4'd8, 48'h0001_0000_0000);
    wr48(4'd4, 48'h0000_FFFF_FFFF);
    ticks(1);
    @(negedge clk);
    chk("R4 wide match", 48'(alarm_irq), 48'h1);
    ticks(3);
    chk("R5 sticky", 48'(alarm_irq), 48'h1);
    wr(4'd1, 16'h0001);
    chk("R5 cleared again", 48'(wake_req), 48'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule